// File: doc/BRIEF.md
# Array Projection Termination and Coordinate Capture

This block watches the state of a square array of binary cells while the array is being eroded step by step by logic elsewhere. Each cycle it folds the array onto its two axes: one bit per row says whether any cell in that row is set, and one bit per column says whether any cell in that column is set. From these two projections it decides, without a clock, whether the surviving region is down to its last step, meaning that the next erosion step will clear it.

The test looks for three neighbouring set positions on either axis. If both projections still hold at least one set bit, and neither holds three set bits side by side, the end flag is raised. On each axis a lowest-index-first encoder turns the projection into a binary position. When the sequencer pulses the capture strobe in a cycle where the end flag is up, those two positions are registered as the centre of the region, and a valid bit is set with them.

Top module: `proj_end_encoder`

## Requirements
- R1: Row projection bit r is the OR of cells r*GRID+0 through r*GRID+GRID-1 of `cellState`; cell bit r*GRID+c is row r, column c.
- R2: Column projection bit c is the OR of cells c, GRID+c, 2*GRID+c, and so on through (GRID-1)*GRID+c.
- R3: `endImminent` is 1 when both projections are nonzero and neither contains three set bits at consecutive indices. This holds even when two set bits are far apart.
- R4: `endImminent` is 0 whenever either projection is all zero.
- R5: The X coordinate is the lowest set index in the column projection and the Y coordinate is the lowest set index in the row projection. Each is a binary number of width clog2(GRID).
- R6: If `captureStrobe` and `endImminent` are both 1 at a rising clock edge, then after that edge `coordX` and `coordY` hold the R5 positions and `coordValid` is 1.
- R7: If `captureStrobe` is 1 and `endImminent` is 0 at an edge, the coordinates keep their values and `coordValid` becomes 0.
- R8: If `captureStrobe` is 0 at an edge, `coordX`, `coordY` and `coordValid` keep their values.
- R9: While `rst_n` is low, `coordValid`, `coordX` and `coordY` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cellState | input | GRID*GRID | Array state, row-major |
| captureStrobe | input | 1 | Request to capture the coordinates |
| rowProj | output | GRID | Row projection (Y axis) |
| colProj | output | GRID | Column projection (X axis) |
| endImminent | output | 1 | Region will vanish on the next erosion step |
| coordX | output | clog2(GRID) | Captured column coordinate |
| coordY | output | clog2(GRID) | Captured row coordinate |
| coordValid | output | 1 | Captured coordinates are valid |

## Verification
The strobe decision and the termination test fall in the same cycle. The register update therefore depends on a combinational verdict formed from the very pattern applied in that cycle. A 4x4 configuration is swept through all 65536 array patterns. The capture strobe is asserted on two patterns out of every three, so that strobe-with-end, strobe-without-end and no-strobe each occur against many projection shapes. After each edge the registered outputs are compared with a bench model that tracks the last accepted coordinates. That model derives the end verdict from the longest run of set projection bits, not from adjacent-triple tests.

// File: rtl/ped_pkg.sv
package ped_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic take;  // load coordinates and set valid
    logic drop;  // clear valid, keep coordinates
  } ped_strobe_t;
endpackage

// File: rtl/ped_low_encoder.sv
module ped_low_encoder #(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [IDXW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (bits[k]) idx = IDXW'(k);
    end
  end
endmodule

// File: rtl/ped_datapath.sv
module ped_datapath
  import ped_pkg::*;
#(
  parameter int GRID = 8,
  localparam int IDXW = $clog2(GRID)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GRID*GRID-1:0] cellState,
  input  ped_strobe_t          strobes,
  output logic [GRID-1:0]      rowProj,
  output logic [GRID-1:0]      colProj,
  output logic [IDXW-1:0]      coordX,
  output logic [IDXW-1:0]      coordY,
  output logic                 coordValid
);
  // OR chains running along rows and down columns.
  logic [GRID-1:0] rowChain [GRID];
  logic [GRID-1:0] colChain [GRID];

  for (genvar r = 0; r < GRID; r++) begin : g_row
    for (genvar c = 0; c < GRID; c++) begin : g_col
      if (c == 0) begin : g_rstart
        assign rowChain[r][c] = cellState[r*GRID+c];
      end else begin : g_rlink
        assign rowChain[r][c] = rowChain[r][c-1] | cellState[r*GRID+c];
      end
      if (r == 0) begin : g_cstart
        assign colChain[r][c] = cellState[r*GRID+c];
      end else begin : g_clink
        assign colChain[r][c] = colChain[r-1][c] | cellState[r*GRID+c];
      end
    end
    assign rowProj[r] = rowChain[r][GRID-1];
  end
  assign colProj = colChain[GRID-1];

  logic [IDXW-1:0] nextX, nextY;

  ped_low_encoder #(.WIDTH(GRID)) u_encX (.bits(colProj), .idx(nextX));
  ped_low_encoder #(.WIDTH(GRID)) u_encY (.bits(rowProj), .idx(nextY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coordX     <= '0;
      coordY     <= '0;
      coordValid <= 1'b0;
    end else if (strobes.take) begin
      coordX     <= nextX;
      coordY     <= nextY;
      coordValid <= 1'b1;
    end else if (strobes.drop) begin
      coordValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ped_control.sv
module ped_control
  import ped_pkg::*;
#(
  parameter int GRID = 8
) (
  input  logic [GRID-1:0] rowProj,
  input  logic [GRID-1:0] colProj,
  input  logic            captureStrobe,
  output logic            endImminent,
  output ped_strobe_t     strobes
);
  logic rowTriple, colTriple;

  always_comb begin
    rowTriple = 1'b0;
    colTriple = 1'b0;
    for (int k = 0; k + 2 < GRID; k++) begin
      rowTriple = rowTriple | (rowProj[k] & rowProj[k+1] & rowProj[k+2]);
      colTriple = colTriple | (colProj[k] & colProj[k+1] & colProj[k+2]);
    end
  end

  assign endImminent  = (|rowProj) & (|colProj) & ~rowTriple & ~colTriple;
  assign strobes.take = captureStrobe & endImminent;
  assign strobes.drop = captureStrobe & ~endImminent;
endmodule

// File: rtl/proj_end_encoder.sv
module proj_end_encoder
  import ped_pkg::*;
#(
  parameter int GRID = 8,
  localparam int IDXW = $clog2(GRID)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GRID*GRID-1:0] cellState,
  input  logic                 captureStrobe,
  output logic [GRID-1:0]      rowProj,
  output logic [GRID-1:0]      colProj,
  output logic                 endImminent,
  output logic [IDXW-1:0]      coordX,
  output logic [IDXW-1:0]      coordY,
  output logic                 coordValid
);
  ped_strobe_t strobes;

  ped_datapath #(.GRID(GRID)) u_dp (
    .clk(clk), .rst_n(rst_n), .cellState(cellState), .strobes(strobes),
    .rowProj(rowProj), .colProj(colProj),
    .coordX(coordX), .coordY(coordY), .coordValid(coordValid)
  );

  ped_control #(.GRID(GRID)) u_ctl (
    .rowProj(rowProj), .colProj(colProj), .captureStrobe(captureStrobe),
    .endImminent(endImminent), .strobes(strobes)
  );
endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
  parameter int GRID = 8,
  localparam int IDXW = $clog2(GRID)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            captureStrobe,
  input logic [GRID-1:0] rowProj,
  input logic [GRID-1:0] colProj,
  input logic            endImminent,
  input logic [IDXW-1:0] coordX,
  input logic [IDXW-1:0] coordY,
  input logic            coordValid
);
  // R1 and R2: an empty array empties both axes together.
  assert_proj_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rowProj == '0) == (colProj == '0)));

  assert_zero_not_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rowProj == '0) || (colProj == '0)) |-> !endImminent);

  assert_capture_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (captureStrobe && endImminent) |=> coordValid);

  assert_miss_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (captureStrobe && !endImminent) |=> (!coordValid && $stable(coordX) && $stable(coordY)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !captureStrobe |=> ($stable(coordX) && $stable(coordY) && $stable(coordValid)));
endmodule

bind proj_end_encoder ped_checker #(.GRID(GRID)) u_checker (
  .clk(clk), .rst_n(rst_n), .captureStrobe(captureStrobe),
  .rowProj(rowProj), .colProj(colProj), .endImminent(endImminent),
  .coordX(coordX), .coordY(coordY), .coordValid(coordValid)
);

// File: tb/tb_proj_end_encoder.sv
module tb_proj_end_encoder;
  localparam int N = 4;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*N-1:0] cellState = '0;
  logic captureStrobe = 1'b0;
  logic [N-1:0] rowProj, colProj;
  logic endImminent;
  logic [W-1:0] coordX, coordY;
  logic coordValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  proj_end_encoder #(.GRID(N)) dut (
    .clk(clk), .rst_n(rst_n), .cellState(cellState), .captureStrobe(captureStrobe),
    .rowProj(rowProj), .colProj(colProj), .endImminent(endImminent),
    .coordX(coordX), .coordY(coordY), .coordValid(coordValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d cells=%h", req, act, exp, cellState);
    end
  endtask

  function automatic int longest_run(input logic [N-1:0] v);
    int run = 0;
    int best = 0;
    for (int k = 0; k < N; k++) begin
      run = v[k] ? run + 1 : 0;
      if (run > best) best = run;
    end
    return best;
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return 0;
  endfunction

  int expX = 0, expY = 0, expV = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", coordValid, 0);
    check("R9 x", coordX, 0);
    check("R9 y", coordY, 0);
    rst_n = 1'b1;
    for (int p = 0; p < (1 << (N*N)); p++) begin
      logic [N-1:0] er, ec;
      int endExp;
      int strobe;
      @(negedge clk);
      cellState = (N*N)'(p);
      strobe = (p % 3 != 0) ? 1 : 0;
      captureStrobe = strobe[0];
      er = '0;
      ec = '0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          if (p[r*N+c]) begin
            er[r] = 1'b1;
            ec[c] = 1'b1;
          end
      if (er == '0 || ec == '0) endExp = 0;
      else endExp = (longest_run(er) < 3 && longest_run(ec) < 3) ? 1 : 0;
      #1;
      check("R1 rowProj", int'(rowProj), int'(er));
      check("R2 colProj", int'(colProj), int'(ec));
      if (er == '0 || ec == '0) check("R4 end on empty axis", endImminent, 0);
      else check("R3 end flag", endImminent, endExp);
      if (strobe == 1 && endExp == 1) begin
        expX = lowest(ec);
        expY = lowest(er);
        expV = 1;
      end else if (strobe == 1) begin
        expV = 0;
      end
      @(posedge clk);
      #1;
      if (strobe == 1 && endExp == 1) begin
        check("R5/R6 coordX", coordX, expX);
        check("R5/R6 coordY", coordY, expY);
        check("R6 valid", coordValid, 1);
      end else if (strobe == 1) begin
        check("R7 valid cleared", coordValid, 0);
        check("R7 x held", coordX, expX);
        check("R7 y held", coordY, expY);
      end else begin
        check("R8 valid held", coordValid, expV);
        check("R8 x held", coordX, expX);
        check("R8 y held", coordY, expY);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule